// File: doc/BRIEF.md
# Byte-Register I2C Master Controller

This block is the processor-facing side of an I2C master. Software reaches it through an 8-bit register port with a byte address and a window of 18 offsets. It holds a set of byte registers: transmit data, target address, control, mode, status, extended status, own-address bytes, clock divider, interrupt mask, transfer count, extended control and direct line control. Some register accesses start bus work: a data write, a control write that requests a read, a data read that pops a received byte, and a target-address write while the bus is held.

The block does not drive SCL and SDA edges itself. It issues whole bus operations (start with address and direction, send a byte, receive a byte, stop) to a transaction engine over a request/acknowledge port. The engine answers each operation with an acknowledge pulse and, when the target refused or the receive failed, a not-acknowledge flag. A register access that causes bus work stalls the register port, with `reg_ready` low, until every operation it causes has completed. Status read afterwards therefore always shows the outcome.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset every mapped offset reads zero, except offset 9 (extended status), which reads 0x8F, and offset 16, which reads 0x0F while both line inputs are high. Offset 0 reads 0xFF.
- R2: Offsets 1, 2, 3, 17 and every offset from 18 up read zero, and writes to them change no register.
- R3: Offset 7 (mode) stores the written value AND 0xDF, and offset 14 (transfer count) stores the value AND 0x77. Offsets 5, 10, 11, 12 and 13 store the value as written.
- R4: A write to offset 0 while the bus is idle issues a write-direction start to device address (offset 4 value >> 1) and then sends the byte. On success, status reads 0x01 (bit 0, transfer pending) and extended status reads 0x00. A data write while the bus is held sends the byte with no new start.
- R5: If the target refuses the address of a start, status bit 0 clears, status bit 2 (error) sets and extended-status bit 0 (abort) sets. No byte is sent after a refused start.
- R6: If the target refuses a sent byte, the same error flags are set and a stop is issued, so the next data write begins with a new start.
- R7: A write to offset 6 with bit 0 (go) and bit 1 (read) set first stops a held bus, then issues a read-direction start. On success it sets status bit 5 (receive data available), clears the error bit and zeroes extended status. On refusal it sets the error flags.
- R8: Reading offset 0 while status bit 5 is clear returns 0xFF and issues no bus operation.
- R9: Reading offset 0 while status bit 5 is set receives one byte and returns it. If control bits [5:4] are zero, it clears status bit 5. Otherwise it stops, starts a new read to the same device, and writes the count minus one back into control bits [5:4].
- R10: A write to offset 4 while the bus is held issues a stop.
- R11: A status write clears only the set bits among positions 1 and 3 of the value. An extended-status write clears the set bits among positions 7 and 3..0.
- R12: A write to offset 15 with bit 0 set restores every register to its reset value and stores nothing. Any other value written there is stored.
- R13: Offset 16 stores written bits 3 (SDA control) and 2 (SCL control) and drives them to `sda_ctl` and `scl_ctl`. Reads return bit 1 as `sda_in` and bit 0 as `scl_in`.
- R14: A write to offset 6 with bit 0 set and bit 1 clear clears status bit 0 and issues no bus operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write request, held until `reg_ready` |
| reg_rd | input | 1 | Register read request, held until `reg_ready` |
| reg_addr | input | AW | Byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while `reg_ready` |
| reg_ready | output | 1 | Access completes at the next edge |
| txn_req | output | 1 | Bus operation request, held until `txn_ack` |
| txn_op | output | 2 | 0 start, 1 send, 2 receive, 3 stop |
| txn_dir_rd | output | 1 | Start direction, 1 for read |
| txn_dev | output | 7 | Target device address |
| txn_wbyte | output | 8 | Byte to send |
| txn_ack | input | 1 | Operation completed this cycle |
| txn_nack | input | 1 | With `txn_ack`: refused or failed |
| txn_rbyte | input | 8 | With `txn_ack` on receive: byte read |
| scl_ctl | output | 1 | Direct SCL control level |
| sda_ctl | output | 1 | Direct SDA control level |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |

## Verification
A wrong bus-held flag shows at the transaction port on the very next register access that depends on it: a data write either skips its start or issues a second one, and a target-address write either misses its stop or emits a stray one. Corrupted status or extended status is visible as soon as the register is read back after the stalled access finishes. The pending-read count is seen through the control register and through the number of stop/start pairs after each pop. It shows up at the first data read where the count should have reached zero.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int BYTE_W = 8;
    localparam int DEV_W  = 7;

    // register offsets
    localparam int OFF_DATA    = 0;
    localparam int OFF_MADR_LO = 4;
    localparam int OFF_MADR_HI = 5;
    localparam int OFF_CTL     = 6;
    localparam int OFF_MODE    = 7;
    localparam int OFF_STAT    = 8;
    localparam int OFF_XSTAT   = 9;
    localparam int OFF_SADR_LO = 10;
    localparam int OFF_SADR_HI = 11;
    localparam int OFF_DIV     = 12;
    localparam int OFF_IMASK   = 13;
    localparam int OFF_XCNT    = 14;
    localparam int OFF_XCTL    = 15;
    localparam int OFF_PIN     = 16;

    // masks and reset values
    localparam logic [BYTE_W-1:0] MODE_MASK  = 8'hDF;
    localparam logic [BYTE_W-1:0] XCNT_MASK  = 8'h77;
    localparam logic [BYTE_W-1:0] STAT_W1C   = 8'h0A;
    localparam logic [BYTE_W-1:0] XSTAT_W1C  = 8'h8F;
    localparam logic [BYTE_W-1:0] XSTAT_INIT = 8'h8F;
    localparam logic [BYTE_W-1:0] IDLE_BYTE  = 8'hFF;

    // bit positions
    localparam int ST_PEND   = 0;
    localparam int ST_ERR    = 2;
    localparam int ST_RXF    = 5;
    localparam int XS_ABORT  = 0;
    localparam int CT_GO     = 0;
    localparam int CT_RD     = 1;
    localparam int CT_CNT_LO = 4;
    localparam int XC_SRST   = 0;
    localparam int PN_SCL    = 2;
    localparam int PN_SDA    = 3;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_STOP  = 2'd3
    } bus_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WSTART,
        S_SEND,
        S_STOP_DONE,
        S_STOP_RD,
        S_RSTART,
        S_RECV,
        S_DONE
    } seq_e;

    typedef struct packed {
        logic [BYTE_W-1:0] dat;
        logic [BYTE_W-1:0] madr_lo;
        logic [BYTE_W-1:0] madr_hi;
        logic [BYTE_W-1:0] ctl;
        logic [BYTE_W-1:0] mode;
        logic [BYTE_W-1:0] stat;
        logic [BYTE_W-1:0] xstat;
        logic [BYTE_W-1:0] sadr_lo;
        logic [BYTE_W-1:0] sadr_hi;
        logic [BYTE_W-1:0] div;
        logic [BYTE_W-1:0] imask;
        logic [BYTE_W-1:0] xcnt;
        logic [BYTE_W-1:0] xctl;
        logic [1:0]        pin;   // {sda, scl} control levels
    } regs_t;

    function automatic regs_t regs_reset();
        regs_t r;
        r       = '0;
        r.xstat = XSTAT_INIT;
        r.pin   = 2'b11;
        return r;
    endfunction

    function automatic regs_t mark_fail(regs_t r);
        regs_t o;
        o                 = r;
        o.stat[ST_PEND]   = 1'b0;
        o.stat[ST_ERR]    = 1'b1;
        o.xstat[XS_ABORT] = 1'b1;
        return o;
    endfunction

    function automatic regs_t mark_ok(regs_t r, int flag_bit);
        regs_t o;
        o                = r;
        o.stat[flag_bit] = 1'b1;
        o.stat[ST_ERR]   = 1'b0;
        o.xstat          = '0;
        return o;
    endfunction

endpackage

// File: rtl/i2cm_read_mux.sv
module i2cm_read_mux
    import i2cm_pkg::*;
#(
    parameter int AW     = 5,
    parameter int WINDOW = 18
) (
    input  regs_t             regs,
    input  logic [AW-1:0]     addr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic [BYTE_W-1:0] rdata
);

    int a_i;

    always_comb begin
        a_i   = int'(addr);
        rdata = '0;
        if (a_i < WINDOW) begin
            case (a_i)
                OFF_DATA:    rdata = IDLE_BYTE;
                OFF_MADR_LO: rdata = regs.madr_lo;
                OFF_MADR_HI: rdata = regs.madr_hi;
                OFF_CTL:     rdata = regs.ctl;
                OFF_MODE:    rdata = regs.mode;
                OFF_STAT:    rdata = regs.stat;
                OFF_XSTAT:   rdata = regs.xstat;
                OFF_SADR_LO: rdata = regs.sadr_lo;
                OFF_SADR_HI: rdata = regs.sadr_hi;
                OFF_DIV:     rdata = regs.div;
                OFF_IMASK:   rdata = regs.imask;
                OFF_XCNT:    rdata = regs.xcnt;
                OFF_XCTL:    rdata = regs.xctl;
                OFF_PIN:     rdata = {4'b0000, regs.pin, sda_in, scl_in};
                default:     rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cm_pkg::*;
#(
    parameter int AW     = 5,
    parameter int WINDOW = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [AW-1:0]     reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              reg_ready,
    output logic              txn_req,
    output logic [1:0]        txn_op,
    output logic              txn_dir_rd,
    output logic [6:0]        txn_dev,
    output logic [7:0]        txn_wbyte,
    input  logic              txn_ack,
    input  logic              txn_nack,
    input  logic [7:0]        txn_rbyte,
    output logic              scl_ctl,
    output logic              sda_ctl,
    input  logic              scl_in,
    input  logic              sda_in
);

    localparam int CNT_W = 2;

    typedef struct packed {
        regs_t             r;
        seq_e              st;
        logic              busy;
        logic [BYTE_W-1:0] rbuf;
    } ctx_t;

    ctx_t q, d;
    logic [BYTE_W-1:0] mux_rdata;
    logic [CNT_W-1:0]  pend;
    int                a_i;
    logic              in_win;

    i2cm_read_mux #(.AW(AW), .WINDOW(WINDOW)) u_rmux (
        .regs   (q.r),
        .addr   (reg_addr),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .rdata  (mux_rdata)
    );

    always_comb begin
        d          = q;
        reg_ready  = 1'b0;
        txn_req    = 1'b0;
        txn_op     = OP_START;
        txn_dir_rd = 1'b0;
        txn_dev    = q.r.madr_lo[BYTE_W-1:1];
        txn_wbyte  = q.r.dat;
        pend       = q.r.ctl[CT_CNT_LO +: CNT_W];
        a_i        = int'(reg_addr);
        in_win     = (a_i < WINDOW);

        case (q.st)
            S_IDLE: begin
                if (reg_wr) begin
                    reg_ready = 1'b1;
                    if (in_win) begin
                        case (a_i)
                            OFF_DATA: begin
                                d.r.dat   = reg_wdata;
                                reg_ready = 1'b0;
                                d.st      = q.busy ? S_SEND : S_WSTART;
                            end
                            OFF_MADR_LO: begin
                                d.r.madr_lo = reg_wdata;
                                if (q.busy) begin
                                    reg_ready = 1'b0;
                                    d.st      = S_STOP_DONE;
                                end
                            end
                            OFF_MADR_HI: d.r.madr_hi = reg_wdata;
                            OFF_CTL: begin
                                d.r.ctl = reg_wdata;
                                if (reg_wdata[CT_GO] && reg_wdata[CT_RD]) begin
                                    reg_ready = 1'b0;
                                    if (q.busy) begin
                                        d.r.stat[ST_PEND] = 1'b0;
                                        d.st              = S_STOP_RD;
                                    end else begin
                                        d.st = S_RSTART;
                                    end
                                end else if (reg_wdata[CT_GO]) begin
                                    d.r.stat[ST_PEND] = 1'b0;
                                end
                            end
                            OFF_MODE:    d.r.mode    = reg_wdata & MODE_MASK;
                            OFF_STAT:    d.r.stat    = q.r.stat & ~(reg_wdata & STAT_W1C);
                            OFF_XSTAT:   d.r.xstat   = q.r.xstat & ~(reg_wdata & XSTAT_W1C);
                            OFF_SADR_LO: d.r.sadr_lo = reg_wdata;
                            OFF_SADR_HI: d.r.sadr_hi = reg_wdata;
                            OFF_DIV:     d.r.div     = reg_wdata;
                            OFF_IMASK:   d.r.imask   = reg_wdata;
                            OFF_XCNT:    d.r.xcnt    = reg_wdata & XCNT_MASK;
                            OFF_XCTL: begin
                                if (reg_wdata[XC_SRST]) d.r = regs_reset();
                                else                    d.r.xctl = reg_wdata;
                            end
                            OFF_PIN:     d.r.pin = {reg_wdata[PN_SDA], reg_wdata[PN_SCL]};
                            default: ;
                        endcase
                    end
                end else if (reg_rd) begin
                    if (a_i == OFF_DATA && q.r.stat[ST_RXF]) begin
                        d.st = S_RECV;
                    end else begin
                        reg_ready = 1'b1;
                    end
                end
            end

            S_WSTART: begin
                txn_req = 1'b1;
                txn_op  = OP_START;
                if (txn_ack) begin
                    if (txn_nack) begin
                        d.r  = mark_fail(q.r);
                        d.st = S_DONE;
                    end else begin
                        d.r    = mark_ok(q.r, ST_PEND);
                        d.busy = 1'b1;
                        d.st   = S_SEND;
                    end
                end
            end

            S_SEND: begin
                txn_req = 1'b1;
                txn_op  = OP_SEND;
                if (txn_ack) begin
                    if (txn_nack) begin
                        d.r  = mark_fail(q.r);
                        d.st = S_STOP_DONE;
                    end else begin
                        d.st = S_DONE;
                    end
                end
            end

            S_STOP_DONE, S_STOP_RD: begin
                txn_req = 1'b1;
                txn_op  = OP_STOP;
                if (txn_ack) begin
                    d.busy = 1'b0;
                    d.st   = (q.st == S_STOP_RD) ? S_RSTART : S_DONE;
                end
            end

            S_RSTART: begin
                txn_req    = 1'b1;
                txn_op     = OP_START;
                txn_dir_rd = 1'b1;
                if (txn_ack) begin
                    d.st = S_DONE;
                    if (txn_nack) begin
                        d.r    = mark_fail(q.r);
                        d.busy = 1'b0;
                    end else begin
                        d.r    = mark_ok(q.r, ST_RXF);
                        d.busy = 1'b1;
                    end
                end
            end

            S_RECV: begin
                txn_req = 1'b1;
                txn_op  = OP_RECV;
                if (txn_ack) begin
                    d.rbuf = txn_nack ? IDLE_BYTE : txn_rbyte;
                    if (pend == '0) begin
                        d.r.stat[ST_RXF] = 1'b0;
                        d.st             = S_DONE;
                    end else begin
                        d.r.ctl[CT_CNT_LO +: CNT_W] = pend - 1'b1;
                        d.st                        = S_STOP_RD;
                    end
                end
            end

            S_DONE: begin
                reg_ready = 1'b1;
                d.st      = S_IDLE;
            end

            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.r    <= regs_reset();
            q.st   <= S_IDLE;
            q.busy <= 1'b0;
            q.rbuf <= '0;
        end else begin
            q <= d;
        end
    end

    assign reg_rdata = (q.st == S_DONE) ? q.rbuf : mux_rdata;
    assign scl_ctl   = q.r.pin[0];
    assign sda_ctl   = q.r.pin[1];

    // request is held, unchanged, until acknowledged (R4)
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_req && !txn_ack) |=> (txn_req && $stable(txn_op)));

    // a byte is only sent on a held bus (R4)
    p_send_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_req && txn_op == OP_SEND) |-> q.busy);

    // refused start or send leaves the error flags set (R5, R6)
    p_fail_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_req && txn_ack && txn_nack && (txn_op == OP_START || txn_op == OP_SEND))
        |=> (q.r.stat[ST_ERR] && !q.r.stat[ST_PEND] && q.r.xstat[XS_ABORT]));

    // completed stop releases the bus (R10)
    p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_req && txn_ack && txn_op == OP_STOP) |=> !q.busy);

    // receive-available flag only rises after an accepted read start (R7)
    p_rxf_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.r.stat[ST_RXF]) |->
        $past(txn_req && txn_ack && !txn_nack && txn_op == OP_START && txn_dir_rd));

endmodule

// File: tb/i2c_byte_master_test.sv
module i2c_byte_master_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       reg_ready;
    logic       txn_req, txn_dir_rd;
    logic [1:0] txn_op;
    logic [6:0] txn_dev;
    logic [7:0] txn_wbyte;
    logic       txn_ack = 1'b0, txn_nack = 1'b0;
    logic [7:0] txn_rbyte = '0;
    logic       scl_ctl, sda_ctl;
    logic       scl_in = 1'b1, sda_in = 1'b1;

    int checks = 0;
    int errors = 0;
    int n_start = 0, n_stop = 0, n_send = 0, n_recv = 0;
    logic [6:0] last_dev = '0;
    logic       last_dir = 1'b0;
    logic [7:0] last_send = '0;
    logic [7:0] rx_val = 8'h3C;

    localparam logic [6:0] GOOD_DEV = 7'h50;
    localparam logic [7:0] BAD_BYTE = 8'hEE;

    always #5 clk = ~clk;

    i2c_byte_master uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ready(reg_ready),
        .txn_req(txn_req), .txn_op(txn_op), .txn_dir_rd(txn_dir_rd),
        .txn_dev(txn_dev), .txn_wbyte(txn_wbyte),
        .txn_ack(txn_ack), .txn_nack(txn_nack), .txn_rbyte(txn_rbyte),
        .scl_ctl(scl_ctl), .sda_ctl(sda_ctl), .scl_in(scl_in), .sda_in(sda_in)
    );

    // transaction engine model
    always @(negedge clk) begin
        if (rst_n && txn_req && !txn_ack) begin
            txn_ack  = 1'b1;
            txn_nack = 1'b0;
            case (txn_op)
                2'd0: begin
                    n_start++;
                    last_dev = txn_dev;
                    last_dir = txn_dir_rd;
                    txn_nack = (txn_dev != GOOD_DEV);
                end
                2'd1: begin
                    n_send++;
                    last_send = txn_wbyte;
                    txn_nack  = (txn_wbyte == BAD_BYTE);
                end
                2'd2: begin
                    n_recv++;
                    txn_rbyte = rx_val;
                    rx_val    = rx_val + 8'h11;
                end
                default: n_stop++;
            endcase
        end else begin
            txn_ack  = 1'b0;
            txn_nack = 1'b0;
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
        end
    endtask

    task automatic access(input bit is_wr, input int a, input logic [7:0] v,
                          output logic [7:0] r);
        @(negedge clk);
        reg_wr    = is_wr;
        reg_rd    = !is_wr;
        reg_addr  = 5'(a);
        reg_wdata = v;
        #1;
        while (!reg_ready) begin
            @(negedge clk);
            #1;
        end
        r = reg_rdata;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_rd = 1'b0;
    endtask

    task automatic wr(input int a, input logic [7:0] v);
        logic [7:0] dummy;
        access(1'b1, a, v, dummy);
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        access(1'b0, a, 8'h00, v);
    endtask

    function automatic logic [7:0] reset_val(input int a);
        if (a == 0)  return 8'hFF;
        if (a == 9)  return 8'h8F;
        if (a == 16) return 8'h0F;
        return 8'h00;
    endfunction

    task automatic sweep_reset(input string tag);
        logic [7:0] v;
        for (int a = 0; a < 32; a++) begin
            rd(a, v);
            check(tag, v, reset_val(a));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int s0, p0, t0, c0;
        logic [7:0] exp_rx;
        exp_rx = 8'h3C;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R2 unmapped offsets read zero
        sweep_reset("R1/R2 reset sweep");

        // R2 writes to unmapped offsets are ignored
        for (int a = 1; a < 4; a++) wr(a, 8'hFF);
        for (int a = 17; a < 32; a++) wr(a, 8'hFF);
        sweep_reset("R2 after unmapped writes");

        // R3 masks, exhaustive
        for (int x = 0; x < 256; x++) begin
            wr(7, 8'(x));
            rd(7, v);
            check("R3 mode mask", v, x & 8'hDF);
            wr(14, 8'(x));
            rd(14, v);
            check("R3 count mask", v, x & 8'h77);
        end
        for (int x = 0; x < 256; x += 37) begin
            for (int k = 0; k < 5; k++) begin
                int off;
                off = (k == 0) ? 5 : 9 + k;
                wr(off, 8'(x + k));
                rd(off, v);
                check("R3 plain store", v, (x + k) & 8'hFF);
            end
        end

        // R12 soft reset
        wr(15, 8'h5A);
        rd(15, v);
        check("R12 store", v, 8'h5A);
        wr(15, 8'h01);
        sweep_reset("R12 soft reset");

        // R11 extended status clear
        wr(9, 8'h0F);
        rd(9, v);
        check("R11 xstat clear", v, 8'h80);

        // R4 data write on idle bus
        wr(4, 8'hA0);
        s0 = n_start; t0 = n_send;
        wr(0, 8'h42);
        check("R4 start count", n_start - s0, 1);
        check("R4 dir", last_dir, 0);
        check("R4 dev", last_dev, 7'h50);
        check("R4 sent byte", last_send, 8'h42);
        check("R4 send count", n_send - t0, 1);
        rd(8, v);
        check("R4 status", v, 8'h01);
        rd(9, v);
        check("R4 xstat", v, 8'h00);
        s0 = n_start;
        wr(0, 8'h43);
        check("R4 held no start", n_start - s0, 0);
        check("R4 held byte", last_send, 8'h43);

        // R10 address write while held
        p0 = n_stop;
        wr(4, 8'hA0);
        check("R10 stop", n_stop - p0, 1);
        s0 = n_start;
        wr(0, 8'h44);
        check("R10 new start", n_start - s0, 1);

        // R6 refused data byte
        p0 = n_stop;
        wr(0, BAD_BYTE);
        rd(8, v);
        check("R6 status", v, 8'h04);
        rd(9, v);
        check("R6 xstat", v, 8'h01);
        check("R6 stop", n_stop - p0, 1);
        s0 = n_start;
        wr(0, 8'h45);
        check("R6 restart", n_start - s0, 1);
        rd(8, v);
        check("R6 status recovered", v, 8'h01);

        // R5 refused start
        wr(4, 8'h20);
        s0 = n_start; t0 = n_send;
        wr(0, 8'h46);
        check("R5 start issued", n_start - s0, 1);
        check("R5 no send", n_send - t0, 0);
        rd(8, v);
        check("R5 status", v, 8'h04);
        rd(9, v);
        check("R5 xstat", v, 8'h01);

        // R11 write-one-to-clear masks
        wr(8, 8'hFF);
        rd(8, v);
        check("R11 status mask", v, 8'h04);
        wr(9, 8'h01);
        rd(9, v);
        check("R11 xstat bit0", v, 8'h00);

        // R14 go without read
        wr(4, 8'hA0);
        wr(0, 8'h47);
        rd(8, v);
        check("R14 pending before", v, 8'h01);
        s0 = n_start; p0 = n_stop;
        wr(6, 8'h01);
        rd(8, v);
        check("R14 pending cleared", v, 8'h00);
        check("R14 no bus op", (n_start - s0) + (n_stop - p0), 0);

        // R7 read start on held bus, R9 pending pops
        s0 = n_start; p0 = n_stop;
        wr(6, 8'h23);
        check("R7 stop first", n_stop - p0, 1);
        check("R7 start", n_start - s0, 1);
        check("R7 dir", last_dir, 1);
        rd(8, v);
        check("R7 status", v, 8'h20);
        rd(9, v);
        check("R7 xstat", v, 8'h00);
        for (int k = 2; k >= 0; k--) begin
            s0 = n_start; p0 = n_stop;
            rd(0, v);
            check("R9 byte", v, exp_rx);
            exp_rx = exp_rx + 8'h11;
            rd(6, v);
            check("R9 count", v, (k == 0) ? 8'h03 : (((k - 1) << 4) | 3));
            check("R9 restarts", n_start - s0, (k == 0) ? 0 : 1);
            check("R9 stops", n_stop - p0, (k == 0) ? 0 : 1);
            rd(8, v);
            check("R9 status", v, (k == 0) ? 8'h00 : 8'h20);
        end

        // R8 read with nothing available
        c0 = n_recv;
        rd(0, v);
        check("R8 idle byte", v, 8'hFF);
        check("R8 no receive", n_recv - c0, 0);

        // R7 refused read start
        wr(4, 8'h20);
        wr(6, 8'h03);
        rd(8, v);
        check("R7 refused status", v, 8'h04);
        rd(9, v);
        check("R7 refused xstat", v, 8'h01);

        // R13 direct line control, exhaustive over control and inputs
        for (int x = 0; x < 64; x++) begin
            scl_in = x[4];
            sda_in = x[5];
            wr(16, 8'(x * 3));
            rd(16, v);
            check("R13 readback", v, ((x * 3) & 8'h0C) | (x[5] << 1) | x[4]);
            check("R13 scl pin", scl_ctl, (x * 3) >> 2 & 1);
            check("R13 sda pin", sda_ctl, (x * 3) >> 3 & 1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule